// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit turns a single-item load or store request into a memory access and an optional update of the base register. It adds an unsigned offset to the base value or subtracts it. The offset comes from an immediate field or from a register operand. Three indexing modes are supported:

- **Plain offset:** the access uses the computed address and the base register is left alone.
- **Pre-indexed:** the access uses the computed address, and the same value is written back to the base register.
- **Post-indexed:** the access uses the untouched base, and the computed value is written back afterwards.

On the memory side the block drives the address, the read and write strobes, the byte enables and the aligned write data. Memory is a synchronous port: read data returns one cycle after the request. The block then aligns that read data into the load result.

The load result and the base-register writeback are presented together, one cycle after the request. If both target the same register, the loaded value wins and the writeback is dropped. Word requests whose address is not 4-byte aligned are flagged and never reach memory.

Top module: `ls_agu`

## Requirements
- R1: With `req_mode` = 00 (plain offset), `mem_addr` equals `req_base` plus or minus the offset in the request cycle, and `wb_valid` stays low in the following cycle.
- R2: With `req_mode` = 01 (pre-indexed), `mem_addr` equals `req_base` plus or minus the offset. In the next cycle `wb_valid` is high, and `wb_data`/`wb_idx` carry that same address and `req_base_idx`.
- R3: With `req_mode` = 10 (post-indexed), `mem_addr` equals `req_base`. In the next cycle `wb_valid` is high with `wb_data` equal to `req_base` plus or minus the offset.
- R4: The offset is unsigned, and an immediate is zero-extended. `req_sub` = 1 subtracts it and `req_sub` = 0 adds it. The arithmetic wraps modulo 2^32.
- R5: `req_use_reg` = 1 takes the offset from `req_roff`; `req_use_reg` = 0 takes it from `req_imm`.
- R6: A word access (`req_byte` = 0) drives `mem_be` = 1111 and `mem_wdata` = `req_store_data`. A word load returns the full `mem_rdata` on `ld_data` in the cycle after the request, with `ld_valid` high and `ld_idx` = `req_dest_idx`.
- R7: A byte store drives the low byte of `req_store_data` on all four lanes. It sets only bit n of `mem_be`, where n = `mem_addr[1:0]`; lane n is bits 8n+7..8n.
- R8: A byte load returns lane `mem_addr[1:0]` of the read word on `ld_data[7:0]`, with bits 31..8 zero, even when the byte's top bit is set.
- R9: A word access whose `mem_addr[1:0]` is not 00 raises `misalign` and keeps `mem_re` and `mem_we` low. It produces neither `ld_valid` nor `wb_valid` in the next cycle, and memory is left unchanged.
- R10: When a pre- or post-indexed load has `req_dest_idx` equal to `req_base_idx`, `ld_valid` is high and `wb_valid` is low in the next cycle.
- R11: `req_mode` = 11 behaves exactly like plain offset: the computed address is used and there is no writeback.
- R12: During and right after reset `ld_valid` and `wb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_load | input | 1 | 1 = load, 0 = store |
| req_byte | input | 1 | 1 = byte, 0 = word |
| req_sub | input | 1 | 1 = subtract offset, 0 = add |
| req_mode | input | 2 | 00 plain, 01 pre-indexed, 10 post-indexed, 11 plain |
| req_use_reg | input | 1 | 1 = register offset, 0 = immediate |
| req_imm | input | IMM_W | Unsigned immediate offset |
| req_roff | input | 32 | Register offset value |
| req_base | input | 32 | Base register value |
| req_base_idx | input | IDX_W | Base register number |
| req_dest_idx | input | IDX_W | Load destination register number |
| req_store_data | input | 32 | Store source value |
| mem_addr | output | 32 | Byte address of the access |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | Read data, one cycle after `mem_re` |
| misalign | output | 1 | Word request with unaligned address |
| ld_valid | output | 1 | Load result present |
| ld_idx | output | IDX_W | Load destination register |
| ld_data | output | 32 | Aligned, zero-extended load result |
| wb_valid | output | 1 | Base writeback present |
| wb_idx | output | IDX_W | Base register to update |
| wb_data | output | 32 | New base value |

## Verification
The load result and the base writeback both leave the block in the cycle after a request. An indexed load can therefore aim both at one register. The bench provokes this with pre-indexed word loads whose destination number equals the base number. The scoreboard then expects the loaded word on the load port and a silent writeback port. It also checks that a post-indexed store with the same two numbers still writes back, since only loads compete. Back-to-back indexed loads with distinct registers confirm that both results appear together when they do not collide.

// File: rtl/ls_agu.sv
module ls_agu #(
  parameter int IMM_W = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_load,
  input  logic             req_byte,
  input  logic             req_sub,
  input  logic [1:0]       req_mode,
  input  logic             req_use_reg,
  input  logic [IMM_W-1:0] req_imm,
  input  logic [31:0]      req_roff,
  input  logic [31:0]      req_base,
  input  logic [IDX_W-1:0] req_base_idx,
  input  logic [IDX_W-1:0] req_dest_idx,
  input  logic [31:0]      req_store_data,
  output logic [31:0]      mem_addr,
  output logic             mem_re,
  output logic             mem_we,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             misalign,
  output logic             ld_valid,
  output logic [IDX_W-1:0] ld_idx,
  output logic [31:0]      ld_data,
  output logic             wb_valid,
  output logic [IDX_W-1:0] wb_idx,
  output logic [31:0]      wb_data
);
  localparam int DW = 32;
  localparam int NB = DW / 8;
  localparam int LW = $clog2(NB);

  logic [DW-1:0]    off, sum;
  logic             go, indexed;
  logic             ld_pend, ld_byte_q, wb_pend;
  logic [LW-1:0]    lane_q;
  logic [IDX_W-1:0] ld_idx_q, wb_idx_q;
  logic [DW-1:0]    wb_data_q;

  assign off      = req_use_reg ? req_roff : DW'(req_imm);
  assign sum      = req_sub ? req_base - off : req_base + off;
  assign mem_addr = (req_mode == 2'b10) ? req_base : sum;
  assign misalign = req_valid & ~req_byte & (mem_addr[LW-1:0] != '0);
  assign go       = req_valid & ~misalign;
  assign indexed  = req_mode[0] ^ req_mode[1];

  assign mem_re    = go & req_load;
  assign mem_we    = go & ~req_load;
  assign mem_be    = req_byte ? (NB'(1) << mem_addr[LW-1:0]) : {NB{1'b1}};
  assign mem_wdata = req_byte ? {NB{req_store_data[7:0]}} : req_store_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_pend   <= 1'b0;
      wb_pend   <= 1'b0;
      ld_byte_q <= 1'b0;
      lane_q    <= '0;
      ld_idx_q  <= '0;
      wb_idx_q  <= '0;
      wb_data_q <= '0;
    end else begin
      ld_pend <= go & req_load;
      wb_pend <= go & indexed;
      if (go) begin
        ld_byte_q <= req_byte;
        lane_q    <= mem_addr[LW-1:0];
        ld_idx_q  <= req_dest_idx;
        wb_idx_q  <= req_base_idx;
        wb_data_q <= sum;
      end
    end
  end

  assign ld_valid = ld_pend;
  assign ld_idx   = ld_idx_q;
  assign ld_data  = ld_byte_q ? DW'(mem_rdata[lane_q*8 +: 8]) : mem_rdata;
  assign wb_valid = wb_pend & ~(ld_pend & (ld_idx_q == wb_idx_q));
  assign wb_idx   = wb_idx_q;
  assign wb_data  = wb_data_q;
endmodule

// File: rtl/ls_agu_chk.sv
module ls_agu_chk #(
  parameter int IMM_W = 12,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_load,
  input logic             req_byte,
  input logic             req_sub,
  input logic [1:0]       req_mode,
  input logic             req_use_reg,
  input logic [IMM_W-1:0] req_imm,
  input logic [31:0]      req_roff,
  input logic [31:0]      req_base,
  input logic [IDX_W-1:0] req_base_idx,
  input logic [IDX_W-1:0] req_dest_idx,
  input logic [31:0]      req_store_data,
  input logic [31:0]      mem_addr,
  input logic             mem_re,
  input logic             mem_we,
  input logic [3:0]       mem_be,
  input logic [31:0]      mem_wdata,
  input logic [31:0]      mem_rdata,
  input logic             misalign,
  input logic             ld_valid,
  input logic [IDX_W-1:0] ld_idx,
  input logic [31:0]      ld_data,
  input logic             wb_valid,
  input logic [IDX_W-1:0] wb_idx,
  input logic [31:0]      wb_data
);
  logic [31:0] c_off, c_new;
  assign c_off = req_use_reg ? req_roff : 32'(req_imm);
  assign c_new = req_sub ? (req_base - c_off) : (req_base + c_off);

  p_post_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_mode == 2'b10 |-> mem_addr == req_base);

  p_pre_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !misalign && req_mode == 2'b01 && !(req_load && req_dest_idx == req_base_idx)
    |=> wb_valid && wb_data == $past(mem_addr) && wb_idx == $past(req_base_idx));

  p_plain_no_wb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_mode == 2'b00 || req_mode == 2'b11) |=> !wb_valid);

  p_byte_be_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_byte |-> $countones(mem_be) == 1);

  p_misalign_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> !mem_re && !mem_we);

  p_misalign_no_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> !ld_valid && !wb_valid);

  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !misalign && req_load && req_mode != 2'b00 && req_mode != 2'b11
    && req_dest_idx == req_base_idx |=> ld_valid && !wb_valid);

  p_byte_zext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_load && req_byte |=> ld_data[31:8] == 24'h0);

  p_post_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_mode == 2'b10 && !misalign && !req_load |=> wb_valid && wb_data == $past(c_new));
endmodule

bind ls_agu ls_agu_chk #(.IMM_W(IMM_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/ls_agu_tb.sv
module ls_agu_tb;
  localparam int IMM_W = 12;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_load = 0, req_byte = 0, req_sub = 0, req_use_reg = 0;
  logic [1:0] req_mode = 0;
  logic [IMM_W-1:0] req_imm = 0;
  logic [31:0] req_roff = 0, req_base = 0, req_store_data = 0;
  logic [IDX_W-1:0] req_base_idx = 0, req_dest_idx = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, ld_data, wb_data;
  logic mem_re, mem_we, misalign, ld_valid, wb_valid;
  logic [3:0] mem_be;
  logic [IDX_W-1:0] ld_idx, wb_idx;

  always #4 clk = ~clk;

  ls_agu #(.IMM_W(IMM_W), .IDX_W(IDX_W)) u_dut (.*);

  logic [31:0] mem [64];
  logic [31:0] ref_mem [64];
  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = 32'h0; ref_mem[i] = 32'h0; end
    mem_rdata = 32'h0;
  end
  always @(posedge clk) begin
    if (mem_we)
      for (int b = 0; b < 4; b++) if (mem_be[b]) mem[mem_addr[7:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    if (mem_re) mem_rdata <= mem[mem_addr[7:2]];
  end

  typedef struct {
    bit lv; bit [3:0] li; bit [31:0] ld;
    bit wv; bit [3:0] wi; bit [31:0] wd;
    string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " ld_valid"}, 32'(ld_valid), 32'(e.lv));
      if (e.lv) begin
        chk({e.tag, " ld_idx"}, 32'(ld_idx), 32'(e.li));
        chk({e.tag, " ld_data"}, ld_data, e.ld);
      end
      chk({e.tag, " wb_valid"}, 32'(wb_valid), 32'(e.wv));
      if (e.wv) begin
        chk({e.tag, " wb_idx"}, 32'(wb_idx), 32'(e.wi));
        chk({e.tag, " wb_data"}, wb_data, e.wd);
      end
    end
  end

  task automatic issue(input string tag, input bit ld, input bit byt, input bit sub,
                       input bit [1:0] mode, input bit ureg, input bit [IMM_W-1:0] imm,
                       input bit [31:0] roff, input bit [31:0] base, input bit [3:0] bidx,
                       input bit [3:0] didx, input bit [31:0] sdata);
    bit [31:0] o, nv, a, w;
    bit [3:0] be;
    bit mis;
    exp_t e;
    @(negedge clk);
    req_valid = 1; req_load = ld; req_byte = byt; req_sub = sub; req_mode = mode;
    req_use_reg = ureg; req_imm = imm; req_roff = roff; req_base = base;
    req_base_idx = bidx; req_dest_idx = didx; req_store_data = sdata;
    #1;
    o   = ureg ? roff : 32'(imm);
    nv  = sub ? base - o : base + o;
    a   = (mode == 2'b10) ? base : nv;
    mis = !byt && (a[1:0] != 2'b00);
    be  = byt ? (4'b0001 << a[1:0]) : 4'b1111;
    w   = byt ? {4{sdata[7:0]}} : sdata;
    chk({tag, " mem_addr"}, mem_addr, a);
    chk({tag, " misalign"}, 32'(misalign), 32'(mis));
    chk({tag, " mem_re"}, 32'(mem_re), 32'(ld && !mis));
    chk({tag, " mem_we"}, 32'(mem_we), 32'(!ld && !mis));
    if (!mis) begin
      chk({tag, " mem_be"}, 32'(mem_be), 32'(be));
      if (!ld) chk({tag, " mem_wdata"}, mem_wdata, w);
    end
    e.tag = tag;
    e.lv = ld && !mis; e.li = didx;
    e.ld = byt ? 32'(ref_mem[a[7:2]][a[1:0]*8 +: 8]) : ref_mem[a[7:2]];
    e.wv = !mis && (mode == 2'b01 || mode == 2'b10) && !(ld && didx == bidx);
    e.wi = bidx; e.wd = nv;
    if (!ld && !mis)
      for (int b = 0; b < 4; b++) if (be[b]) ref_mem[a[7:2]][b*8 +: 8] = w[b*8 +: 8];
    q.push_back(e);
  endtask

  task automatic idle();
    exp_t e;
    @(negedge clk);
    req_valid = 0;
    e.tag = "idle"; e.lv = 0; e.li = 0; e.ld = 0; e.wv = 0; e.wi = 0; e.wd = 0;
    q.push_back(e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 ld_valid in reset", 32'(ld_valid), 32'd0);
    chk("R12 wb_valid in reset", 32'(wb_valid), 32'd0);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R12 ld_valid after reset", 32'(ld_valid), 32'd0);
    chk("R12 wb_valid after reset", 32'(wb_valid), 32'd0);

    issue("R1 R4 R6 word store plain add imm", 0,0,0,2'b00,0,12'd8,0,32'h40,1,0,32'h11223344);
    issue("R5 R4 R6 word load plain sub reg", 1,0,1,2'b00,1,12'hFFF,32'd8,32'h50,2,3,0);
    issue("R2 R7 byte store pre sub", 0,1,1,2'b01,0,12'd1,0,32'h4B,5,0,32'hDEAD_BEAA);
    issue("R3 R8 byte load post add", 1,1,0,2'b10,0,12'd4,0,32'h4A,7,6,0);
    issue("R10 word load pre dest eq base", 1,0,0,2'b01,0,12'd4,0,32'h44,4,4,0);
    issue("R10 store post same idx still wb", 0,0,0,2'b10,1,0,32'h10,32'h60,4,4,32'h8899AABB);
    for (int n = 0; n < 4; n++)
      issue("R8 R7 byte load lane sweep", 1,1,0,2'b00,0,12'(n),0,32'h60,1,9,0);
    issue("R9 misaligned word load pre", 1,0,0,2'b01,0,12'd1,0,32'h44,2,3,0);
    issue("R9 misaligned word store", 0,0,0,2'b00,0,12'd2,0,32'h60,2,3,32'hFFFF_FFFF);
    issue("R9 memory unchanged", 1,0,0,2'b00,0,12'd0,0,32'h60,2,3,0);
    issue("R11 mode 11 plain", 1,0,0,2'b11,0,12'd8,0,32'h40,8,10,0);
    issue("R4 wrap store", 0,0,1,2'b01,0,12'd8,0,32'h4,11,0,32'hCAFEF00D);
    issue("R4 wrap load", 1,0,0,2'b00,0,12'd12,0,32'hFFFF_FFF0,11,12,0);
    issue("R2 R3 b2b load pre", 1,0,0,2'b01,1,0,32'h8,32'h40,13,14,0);
    issue("R2 R3 b2b load post", 1,0,1,2'b10,1,0,32'h4,32'h60,1,2,0);
    issue("R7 byte store lane3", 0,1,0,2'b00,0,12'd3,0,32'h80,0,0,32'h5A);
    issue("R8 byte load lane3", 1,1,0,2'b00,0,12'd3,0,32'h80,0,15,0);
    issue("R5 imm ignores reg", 1,0,0,2'b00,0,12'd0,32'h44,32'h48,0,1,0);
    idle();
    idle();
    wait (q.size() == 0);
    @(negedge clk);
    finish_run();
  end
endmodule